// File: doc/BRIEF.md
# SD/MMC Host Command Issue and Response Checker

This block sits between the host's command register and the card-side command engine of an SD/MMC host controller. When the host writes a 16-bit command word, the block splits it into its fields and captures the 32-bit argument presented with it. It then raises a request to the card port carrying the command index and the argument. When the card port acknowledges, it delivers up to sixteen response bytes and the number of bytes it actually received.

The block checks that the response is long enough for the response class that the command word asks for. It tests card-status error bits for the classes that carry a card status, and it packs the response into eight 16-bit words, last byte pair first. In the cycle after the acknowledge it emits a one-cycle status-set pulse. A separate status register elsewhere ORs that pulse in. Commands of the addressed-data-transfer type also pulse a transfer-start strobe with the data direction, which resets the data FIFO and arms the data path.

Top module: `mmc_cmd_engine`

## Requirements
- R1: Command word fields are index [5:0], init flag [7], response class [10:8], busy flag [11], command type [13:12] and direction [15]. An accepted command (cmd_wr while card_req is low) raises card_req in the next cycle, with card_idx equal to the index and card_arg equal to cmd_arg as sampled at acceptance.
- R2: A command with the init flag set and index 0 sends nothing to the card. In the next cycle stat_vld pulses with stat_set = 0x0001 and card_req stays low.
- R3: Every accepted command clears all eight response words, so rsp_words reads 0 in the cycle after acceptance.
- R4: A command of type 3 (addressed data transfer), other than the init-with-index-0 case, pulses xfer_start for one cycle after acceptance, with xfer_dir equal to bit 15. Other types leave xfer_start low.
- R5: Classes 1, 3 and 6 need card_rsp_len of at least 4 and class 2 needs at least 16. A shorter response yields stat_set = 0x0080 (timeout, bit 7) only, with no command-end bit, and leaves the response words at 0.
- R6: For class 1, the card status is bytes 0..3 with byte 0 as the most significant. Any bit set under mask 0xFDF90000 sets stat_set bit 14. When ake_en is 1, bit 3 is added to the mask. Class 1 with the busy flag is checked the same way, and card_busy_rsp is 1 while it is outstanding.
- R7: For class 6 the checked status is only {byte 2, byte 3}, under mask 0xE008. A match sets bit 14. Bytes 0 and 1 never set it.
- R8: For class 3, bit 31 of {byte 0..3} being clear sets stat_set bit 12.
- R9: On a response that passes its length check with class 1, 2, 3 or 6, word k (bits [16k+15:16k] of rsp_words) becomes {byte 14-2k, byte 15-2k}. Byte i is card_rsp[8i+7:8i].
- R10: A command that does not time out sets stat_set bit 0. When the index is 12, it sets bits 0 and 2 together.
- R11: stat_vld pulses exactly in the cycle after card_req and card_ack are both high. card_req holds with a stable index and argument until card_ack, and cmd_wr while card_req is high is ignored.
- R12: Classes 0, 4, 5 and 7 have no length check and store nothing. They give the command-end bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host writes a command word this cycle |
| cmd_word | input | 16 | Command word |
| cmd_arg | input | 32 | Command argument, captured on acceptance |
| ake_en | input | 1 | Adds the authentication-sequence bit to the class 1 error mask |
| card_req | output | 1 | Command outstanding at the card port |
| card_idx | output | 6 | Command index to the card |
| card_arg | output | 32 | Argument to the card |
| card_busy_rsp | output | 1 | Outstanding command expects a busy-signalling response |
| card_ack | input | 1 | Card port returns the response |
| card_rsp_len | input | 5 | Number of response bytes received (0..16) |
| card_rsp | input | 128 | Response bytes, byte i at [8i+7:8i] |
| stat_vld | output | 1 | One-cycle status-set pulse |
| stat_set | output | 16 | Status bits to set |
| xfer_start | output | 1 | FIFO reset and data transfer start pulse |
| xfer_dir | output | 1 | Direction of the started transfer |
| rsp_words | output | 128 | Eight 16-bit response words, word k at [16k+15:16k] |

## Verification
The assertions assume that card_ack only arrives while card_req is high and that card_rsp_len never exceeds 16. They also assume that the host keeps cmd_word valid in any cycle where cmd_wr is high. The bench drives every input at the falling edge. It raises the acknowledge only after it has seen the request, holds it for a single cycle, and uses lengths within 0..16. It drives cmd_wr during an outstanding request to probe the ignore rule.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

    localparam int RSP_BYTES = 16;
    localparam int RSP_WORDS = RSP_BYTES / 2;
    localparam int STAT_W    = 16;

    // response class codes
    localparam logic [2:0] RC_NONE = 3'd0;
    localparam logic [2:0] RC_CSTS = 3'd1;
    localparam logic [2:0] RC_LONG = 3'd2;
    localparam logic [2:0] RC_OCR  = 3'd3;
    localparam logic [2:0] RC_ADDR = 3'd6;

    localparam logic [1:0] CT_DATA = 2'd3;

    // status bit positions
    localparam int SB_END  = 0;
    localparam int SB_STOP = 2;
    localparam int SB_TMO  = 7;
    localparam int SB_OCR  = 12;
    localparam int SB_CERR = 14;

    localparam logic [31:0] CSTS_ERR_MASK = 32'hFDF9_0000;
    localparam logic [31:0] AKE_ERR_BIT   = 32'h0000_0008;
    localparam logic [15:0] ADDR_ERR_MASK = 16'hE008;

    typedef struct packed {
        logic       dir;
        logic [1:0] ctype;
        logic       busy;
        logic [2:0] rclass;
        logic       init;
        logic [5:0] idx;
    } cmd_t;

    function automatic cmd_t split_cmd(input logic [15:0] w);
        cmd_t c;
        c.idx    = w[5:0];
        c.init   = w[7];
        c.rclass = w[10:8];
        c.busy   = w[11];
        c.ctype  = w[13:12];
        c.dir    = w[15];
        return c;
    endfunction

    function automatic logic is_init_nop(input cmd_t c);
        return c.init && (c.idx == 6'd0);
    endfunction

endpackage

// File: rtl/mmc_rsp_eval.sv
module mmc_rsp_eval
    import mmc_cmd_pkg::*;
#(
    parameter int LEN_W    = 5,
    parameter int STOP_IDX = 12
) (
    input  cmd_t                       cmd,
    input  logic [LEN_W-1:0]           len,
    input  logic [8*RSP_BYTES-1:0]     bytes_in,
    input  logic                       ake_en,
    output logic [STAT_W-1:0]          set_bits,
    output logic                       store
);
    logic [31:0]      csts;
    logic [15:0]      short_csts;
    logic [LEN_W-1:0] need;
    logic             has_data;
    logic             tmo;
    logic             cerr;

    always_comb begin
        csts       = {bytes_in[7:0], bytes_in[15:8], bytes_in[23:16], bytes_in[31:24]};
        short_csts = {bytes_in[23:16], bytes_in[31:24]};
        need       = '0;
        has_data   = 1'b1;
        case (cmd.rclass)
            RC_CSTS, RC_OCR, RC_ADDR: need = LEN_W'(4);
            RC_LONG:                  need = LEN_W'(16);
            default:                  has_data = 1'b0;
        endcase
        tmo  = len < need;
        cerr = 1'b0;
        if (cmd.rclass == RC_CSTS)
            cerr = |(csts & (CSTS_ERR_MASK | (ake_en ? AKE_ERR_BIT : 32'h0)));
        else if (cmd.rclass == RC_ADDR)
            cerr = |(short_csts & ADDR_ERR_MASK);

        set_bits = '0;
        if (tmo) begin
            set_bits[SB_TMO] = 1'b1;
        end else begin
            set_bits[SB_END]  = 1'b1;
            set_bits[SB_STOP] = (cmd.idx == 6'(STOP_IDX));
            set_bits[SB_CERR] = cerr;
            set_bits[SB_OCR]  = (cmd.rclass == RC_OCR) && !csts[31];
        end
        store = has_data && !tmo;
    end
endmodule

// File: rtl/mmc_rsp_pack.sv
module mmc_rsp_pack
    import mmc_cmd_pkg::*;
(
    input  logic [8*RSP_BYTES-1:0]  bytes_in,
    output logic [16*RSP_WORDS-1:0] words
);
    // word k takes the byte pair counted from the end, earlier byte high
    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        localparam int HI = RSP_BYTES - 2 - 2 * k;
        localparam int LO = RSP_BYTES - 1 - 2 * k;
        assign words[16*k +: 16] = {bytes_in[8*HI +: 8], bytes_in[8*LO +: 8]};
    end
endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
    import mmc_cmd_pkg::*;
#(
    parameter int LEN_W    = 5,
    parameter int STOP_IDX = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_wr,
    input  logic [15:0]                 cmd_word,
    input  logic [31:0]                 cmd_arg,
    input  logic                        ake_en,
    output logic                        card_req,
    output logic [5:0]                  card_idx,
    output logic [31:0]                 card_arg,
    output logic                        card_busy_rsp,
    input  logic                        card_ack,
    input  logic [LEN_W-1:0]            card_rsp_len,
    input  logic [8*RSP_BYTES-1:0]      card_rsp,
    output logic                        stat_vld,
    output logic [STAT_W-1:0]           stat_set,
    output logic                        xfer_start,
    output logic                        xfer_dir,
    output logic [16*RSP_WORDS-1:0]     rsp_words
);
    cmd_t                    cur_q;
    cmd_t                    new_cmd;
    logic [31:0]             arg_q;
    logic                    accept;
    logic                    finish;
    logic [STAT_W-1:0]       eval_set;
    logic                    eval_store;
    logic [16*RSP_WORDS-1:0] packed_words;

    assign new_cmd = split_cmd(cmd_word);
    assign accept  = cmd_wr && !card_req;
    assign finish  = card_req && card_ack;

    mmc_rsp_eval #(.LEN_W(LEN_W), .STOP_IDX(STOP_IDX)) eval_i (
        .cmd      (cur_q),
        .len      (card_rsp_len),
        .bytes_in (card_rsp),
        .ake_en   (ake_en),
        .set_bits (eval_set),
        .store    (eval_store)
    );

    mmc_rsp_pack pack_i (
        .bytes_in (card_rsp),
        .words    (packed_words)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            arg_q      <= '0;
            card_req   <= 1'b0;
            stat_vld   <= 1'b0;
            stat_set   <= '0;
            xfer_start <= 1'b0;
            xfer_dir   <= 1'b0;
            rsp_words  <= '0;
        end else begin
            stat_vld   <= 1'b0;
            stat_set   <= '0;
            xfer_start <= 1'b0;
            if (accept) begin
                cur_q     <= new_cmd;
                arg_q     <= cmd_arg;
                rsp_words <= '0;
                if (is_init_nop(new_cmd)) begin
                    stat_vld         <= 1'b1;
                    stat_set[SB_END] <= 1'b1;
                end else begin
                    card_req <= 1'b1;
                    if (new_cmd.ctype == CT_DATA) begin
                        xfer_start <= 1'b1;
                        xfer_dir   <= new_cmd.dir;
                    end
                end
            end else if (finish) begin
                card_req <= 1'b0;
                stat_vld <= 1'b1;
                stat_set <= eval_set;
                if (eval_store)
                    rsp_words <= packed_words;
            end
        end
    end

    assign card_idx      = cur_q.idx;
    assign card_arg      = arg_q;
    assign card_busy_rsp = card_req && cur_q.busy && (cur_q.rclass == RC_CSTS);

endmodule

// File: rtl/mmc_cmd_engine_chk.sv
module mmc_cmd_engine_chk (
    input logic         clk,
    input logic         rst,
    input logic         cmd_wr,
    input logic [15:0]  cmd_word,
    input logic         card_req,
    input logic [5:0]   card_idx,
    input logic [31:0]  card_arg,
    input logic         card_ack,
    input logic         stat_vld,
    input logic [15:0]  stat_set,
    input logic         xfer_start,
    input logic [127:0] rsp_words
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        card_req && !card_ack |=> card_req);

    // R11
    req_fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
        card_req && !card_ack |=> $stable(card_idx) && $stable(card_arg));

    // R11
    stat_origin_chk: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> ($past(card_req && card_ack) || $past(cmd_wr && !card_req)));

    // R5
    tmo_excl_chk: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> !(stat_set[7] && stat_set[0]));

    // R4
    xfer_origin_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(cmd_wr && !card_req && cmd_word[13:12] == 2'd3));

    // R2
    init_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !card_req && cmd_word[7] && cmd_word[5:0] == 6'd0 |=> !card_req && stat_set == 16'h0001);

    // R3
    rsp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !card_req |=> rsp_words == '0);
endmodule

bind mmc_cmd_engine mmc_cmd_engine_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .cmd_word   (cmd_word),
    .card_req   (card_req),
    .card_idx   (card_idx),
    .card_arg   (card_arg),
    .card_ack   (card_ack),
    .stat_vld   (stat_vld),
    .stat_set   (stat_set),
    .xfer_start (xfer_start),
    .rsp_words  (rsp_words)
);

// File: tb/mmc_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module mmc_cmd_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_word = '0;
    logic [31:0]  cmd_arg = '0;
    logic         ake_en = 1'b0;
    logic         card_req;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg;
    logic         card_busy_rsp;
    logic         card_ack = 1'b0;
    logic [4:0]   card_rsp_len = '0;
    logic [127:0] card_rsp = '0;
    logic         stat_vld;
    logic [15:0]  stat_set;
    logic         xfer_start;
    logic         xfer_dir;
    logic [127:0] rsp_words;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    mmc_cmd_engine dut_i (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
        .ake_en(ake_en), .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
        .card_busy_rsp(card_busy_rsp), .card_ack(card_ack), .card_rsp_len(card_rsp_len),
        .card_rsp(card_rsp), .stat_vld(stat_vld), .stat_set(stat_set),
        .xfer_start(xfer_start), .xfer_dir(xfer_dir), .rsp_words(rsp_words)
    );

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural expectation of the status pulse
    function automatic logic [15:0] model_stat(input logic [15:0] w, input int len,
                                               input logic [7:0] b [16], input bit ake);
        int rc = int'(w[10:8]);
        int need = 0;
        logic [31:0] cs = {b[0], b[1], b[2], b[3]};
        logic [15:0] s = 16'h0;
        if (rc == 1 || rc == 3 || rc == 6) need = 4;
        if (rc == 2) need = 16;
        if (len < need) return 16'h0080;
        s = 16'h0001;
        if (w[5:0] == 6'd12) s = s | 16'h0004;
        if (rc == 1 && ((cs & (32'hFDF90000 | (ake ? 32'h8 : 32'h0))) != 0)) s = s | 16'h4000;
        if (rc == 6 && (({b[2], b[3]} & 16'hE008) != 0)) s = s | 16'h4000;
        if (rc == 3 && !cs[31]) s = s | 16'h1000;
        return s;
    endfunction

    function automatic logic [127:0] model_words(input logic [15:0] w, input int len,
                                                 input logic [7:0] b [16]);
        int rc = int'(w[10:8]);
        logic [127:0] r = '0;
        if (!((rc == 1 || rc == 3 || rc == 6) && len >= 4) && !(rc == 2 && len >= 16))
            return r;
        for (int k = 0; k < 8; k++) r[16*k +: 16] = {b[14-2*k], b[15-2*k]};
        return r;
    endfunction

    // one full command; poke_busy drives a second write while the request waits
    task automatic run_cmd(input logic [15:0] w, input logic [31:0] a, input int len,
                           input logic [7:0] b [16], input int delay, input bit poke_busy,
                           input string tag);
        bit nop = w[7] && (w[5:0] == 6'd0);
        @(negedge clk);
        cmd_word = w; cmd_arg = a; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(rsp_words, '0, {tag, " R3 cleared"});
        chk(xfer_start, (w[13:12] == 2'd3) && !nop, {tag, " R4 start"});
        if (w[13:12] == 2'd3 && !nop) chk(xfer_dir, w[15], {tag, " R4 dir"});
        if (nop) begin
            chk(card_req, 0, {tag, " R2 no req"});
            chk({stat_vld, stat_set}, {1'b1, 16'h0001}, {tag, " R2 status"});
            return;
        end
        chk({card_req, card_idx, card_arg}, {1'b1, w[5:0], a}, {tag, " R1 request"});
        chk(card_busy_rsp, w[10:8] == 3'd1 && w[11], {tag, " R6 busy variant"});
        for (int d = 0; d < delay; d++) begin
            if (poke_busy && d == 0) begin cmd_word = 16'h013F; cmd_arg = ~a; cmd_wr = 1'b1; end
            @(negedge clk);
            cmd_wr = 1'b0;
            chk({card_req, card_idx, card_arg, stat_vld}, {1'b1, w[5:0], a, 1'b0}, {tag, " R11 hold"});
        end
        card_ack = 1'b1; card_rsp_len = 5'(len);
        for (int i = 0; i < 16; i++) card_rsp[8*i +: 8] = b[i];
        @(negedge clk);
        card_ack = 1'b0;
        chk(card_req, 0, {tag, " R11 req drop"});
        chk({stat_vld, stat_set}, {1'b1, model_stat(w, len, b, ake_en)}, {tag, " R5-R10 status"});
        chk(rsp_words, model_words(w, len, b), {tag, " R9 words"});
        @(negedge clk);
        chk({stat_vld, card_req, xfer_start}, 3'b000, {tag, " R11 single pulse"});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b [16];
        for (int i = 0; i < 16; i++) b[i] = 8'(8'h10 + 8'(i * 17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({card_req, stat_vld, xfer_start, rsp_words}, '0, "reset state");

        // R1 R9 R10 class 1, clean status, length 6
        b[0] = 8'h00; b[1] = 8'h00; b[2] = 8'h09; b[3] = 8'h00;
        run_cmd(16'h010D, 32'hDEAD_BEEF, 6, b, 2, 0, "R1 cls1 ok");
        // R6 error bit 31
        b[0] = 8'h80;
        run_cmd(16'h0111, 32'h0000_0001, 4, b, 0, 0, "R6 cls1 err");
        // R6 ake bit without and with enable
        b[0] = 8'h00; b[3] = 8'h08;
        run_cmd(16'h0111, 32'h5, 4, b, 1, 0, "R6 ake off");
        ake_en = 1'b1;
        run_cmd(16'h0111, 32'h5, 4, b, 1, 0, "R6 ake on");
        ake_en = 1'b0;
        // R5 short class 1
        run_cmd(16'h0111, 32'h7, 3, b, 0, 0, "R5 cls1 short");
        // R9 class 2 full, R5 class 2 short
        run_cmd(16'h0202, 32'h0, 16, b, 3, 0, "R9 cls2");
        run_cmd(16'h0202, 32'h0, 15, b, 0, 0, "R5 cls2 short");
        // R8 class 3 busy clear / set
        b[0] = 8'h00;
        run_cmd(16'h0329, 32'h00FF_8000, 4, b, 0, 0, "R8 ocr busy");
        b[0] = 8'hC0;
        run_cmd(16'h0329, 32'h00FF_8000, 4, b, 0, 0, "R8 ocr ready");
        // R7 class 6: error in byte 2, then only bytes 0..1 set
        b[0] = 8'h00; b[1] = 8'h00; b[2] = 8'h80; b[3] = 8'h00;
        run_cmd(16'h0603, 32'h0, 4, b, 1, 0, "R7 cls6 err");
        b[0] = 8'hFF; b[1] = 8'hFF; b[2] = 8'h00; b[3] = 8'h01;
        run_cmd(16'h0603, 32'h0, 4, b, 1, 0, "R7 cls6 high bytes");
        // R10 index 12 busy variant
        b[0] = 8'h00; b[1] = 8'h00;
        run_cmd(16'h090C, 32'h0, 4, b, 2, 0, "R10 stop");
        // R4 data command, read direction, then write direction
        run_cmd(16'hB111, 32'h200, 4, b, 1, 0, "R4 data rd");
        run_cmd(16'h3118, 32'h400, 4, b, 0, 0, "R4 data wr");
        // R12 no response and reserved class
        run_cmd(16'h0000, 32'h0, 0, b, 0, 0, "R12 none");
        run_cmd(16'h0507, 32'h0, 16, b, 0, 0, "R12 reserved");
        // R2 init with index 0; init with nonzero index behaves normally
        run_cmd(16'h3080, 32'h0, 0, b, 0, 0, "R2 init nop");
        run_cmd(16'h0181, 32'h9, 4, b, 0, 0, "R2 init idx1");
        // R11 write during outstanding request is ignored
        run_cmd(16'h0110, 32'hCAFE_0001, 4, b, 3, 1, "R11 busy write");
        // R3 clears a previously stored response
        run_cmd(16'h0202, 32'h0, 16, b, 0, 0, "R3 fill");
        run_cmd(16'h0000, 32'h0, 0, b, 0, 0, "R3 clear after fill");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule